// File: doc/BRIEF.md
# Trap and Debug Entry Controller

This block decides, cycle by cycle, whether an in-order pipelined core keeps running or leaves normal flow. It can go to the exception handler, to the interrupt handler, or into debug mode. It watches the instruction in the execute stage: whether one is present and whether it completes in this cycle. It also sees the exception flags of that instruction, a halt request, a single-step enable, the debug-mode flag and a pending-and-enabled interrupt. From these it drives a PC redirect with its selector and two fetch controls: one clears the instruction-valid bit, the other stops new instructions from entering decode. It also drives write strobes and values for the exception PC, the exception cause, the debug PC and the debug cause.

A decision is only made at an instruction boundary. That is either the cycle in which the current instruction completes, or a cycle with no instruction present. An instruction that is still running is never cut short. Entry on a halt request takes two cycles. In the first cycle fetch is held and the next PC is saved. In the second cycle the request is checked again, and entry is abandoned if the request has gone away.

Top module: `trapctl_top`

## Requirements
- R1: While reset is active, and in an idle cycle with no requests, no redirect, no clear, no hold and no write strobe is asserted.
- R2: While an instruction is present but not done (`instr_valid_i`=1, `instr_done_i`=0), nothing is taken, even with an interrupt or halt request pending.
- R3: An instruction that completes with an exception redirects with `pc_sel_o`=2, clears valid and writes the exception PC with `pc_id_i`. The cause is {0, code}, where illegal=2 and environment call=11, and illegal wins over environment call. This outranks a halt request and an interrupt in the same cycle.
- R4: A completing jump redirects with `pc_sel_o`=1 only when it raises no exception; an illegal jump redirects with selector 2 instead, and the exception PC is the jump's own PC.
- R5: A completing breakpoint enters debug at once (`pc_sel_o`=3, valid cleared), with debug PC = `pc_id_i` and debug cause 1. It outranks a halt request.
- R6: A halt request at a boundary outside debug mode first asserts only `fetch_hold_o` and saves `pc_next_i`. If the request is still high one cycle later, the block enters debug: redirect with selector 3, clear, hold, debug PC = the saved value, debug cause 3.
- R7: If the halt request is low in that second cycle, entry is abandoned: no redirect, no strobe, and the hold is released.
- R8: A halt request outranks an interrupt arriving at the same boundary; no exception PC is written.
- R9: An interrupt at a boundary outside debug mode redirects with selector 2, clears valid, writes the exception PC with `pc_next_i` and the cause {1, `irq_id_i`}.
- R10: In debug mode, interrupts, halt requests and single-step are ignored.
- R11: With single-step enabled, a completing legal instruction enters debug with debug PC = `pc_next_i` and cause 4. An idle cycle with step enabled takes no action.
- R12: If the stepped instruction raises an exception, the exception PC and cause are written as in R3. The core then enters debug (selector 3) with debug PC = `trap_vec_i` and cause 4, instead of going to the handler.
- R13: `retire_o` pulses for exactly the cycles in which an instruction completes, whether it was legal or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_valid_i | input | 1 | An instruction occupies the execute stage |
| instr_done_i | input | 1 | That instruction completes this cycle |
| exc_illegal_i | input | 1 | Completing instruction is illegal |
| exc_ecall_i | input | 1 | Completing instruction is an environment call |
| exc_ebreak_i | input | 1 | Completing instruction is a breakpoint |
| jump_req_i | input | 1 | Completing instruction requests a jump or branch redirect |
| pc_id_i | input | XLEN | PC of the current instruction |
| pc_next_i | input | XLEN | PC of the next instruction |
| trap_vec_i | input | XLEN | Exception handler address |
| debug_req_i | input | 1 | Halt request |
| step_en_i | input | 1 | Single-step enable |
| debug_mode_i | input | 1 | Core is in debug mode |
| irq_pending_i | input | 1 | An interrupt is pending and enabled |
| irq_id_i | input | CODE_W | Identifier of the pending interrupt |
| pc_set_o | output | 1 | Redirect the PC this cycle |
| pc_sel_o | output | 2 | Redirect target: 1 jump, 2 handler, 3 debug |
| instr_valid_clr_o | output | 1 | Clear the fetch instruction-valid bit |
| fetch_hold_o | output | 1 | Stop pushing into the fetch-to-decode register |
| mepc_we_o | output | 1 | Write strobe for the exception PC |
| mepc_o | output | XLEN | Exception PC value |
| mcause_o | output | CODE_W+1 | Exception cause value, top bit marks an interrupt |
| dpc_we_o | output | 1 | Write strobe for the debug PC and cause |
| dpc_o | output | XLEN | Debug PC value |
| dcause_o | output | 3 | Debug entry cause: 1 breakpoint, 3 halt, 4 step |
| retire_o | output | 1 | Single-cycle retire pulse |

## Verification
The critical collisions are several claims that fall on the same instruction boundary. The bench provokes these by raising an exception, a halt request and an interrupt together on one completing instruction. It does the same with a breakpoint together with a halt request, and with a halt request together with an interrupt in an idle cycle. It judges each case by which strobes fire and which selector and cause appear. Single-step combined with an exception is the second overlap. There one completion must write the exception PC and cause and the debug PC and cause in the same cycle, with the redirect going to debug. The bench also withdraws a halt request in the confirmation cycle to show that entry is abandoned.

// File: rtl/trapctl_pkg.sv
package trapctl_pkg;
   typedef enum logic [1:0] {
      PCS_NONE = 2'd0,
      PCS_JUMP = 2'd1,
      PCS_EXC  = 2'd2,
      PCS_DBG  = 2'd3
   } pc_sel_e;

   typedef enum logic [2:0] {
      ACT_NONE,
      ACT_JUMP,
      ACT_EXC,
      ACT_EXC_STEP,
      ACT_EBRK,
      ACT_HALT,
      ACT_STEP,
      ACT_IRQ
   } act_e;

   localparam logic [2:0] DCAUSE_EBREAK = 3'd1;
   localparam logic [2:0] DCAUSE_HALT   = 3'd3;
   localparam logic [2:0] DCAUSE_STEP   = 3'd4;

   localparam int unsigned EXC_CODE_ILLEGAL = 2;
   localparam int unsigned EXC_CODE_ECALL   = 11;
endpackage

// File: rtl/trapctl_arbiter.sv
module trapctl_arbiter
   import trapctl_pkg::*;
#(
   parameter bit GATE_IN_DEBUG = 1'b1
) (
   input  logic debug_mode_i,
   input  logic instr_valid_i,
   input  logic instr_done_i,
   input  logic exc_illegal_i,
   input  logic exc_ecall_i,
   input  logic exc_ebreak_i,
   input  logic jump_req_i,
   input  logic debug_req_i,
   input  logic step_en_i,
   input  logic irq_pending_i,
   output act_e act_o,
   output logic dreq_live_o,
   output logic retire_o
);
   logic irq_g, step_g;

   // Request gating against debug mode, chosen at elaboration
   generate
      if (GATE_IN_DEBUG) begin : g_gate
         assign dreq_live_o = debug_req_i   & ~debug_mode_i;
         assign irq_g       = irq_pending_i & ~debug_mode_i;
         assign step_g      = step_en_i     & ~debug_mode_i;
      end else begin : g_pass
         logic unused_mode;
         assign unused_mode = debug_mode_i;
         assign dreq_live_o = debug_req_i;
         assign irq_g       = irq_pending_i;
         assign step_g      = step_en_i;
      end
   endgenerate

   logic done, boundary, exc;
   assign done     = instr_valid_i & instr_done_i;
   assign boundary = ~instr_valid_i | instr_done_i;
   assign exc      = done & (exc_illegal_i | exc_ecall_i);
   assign retire_o = done;

   // Fixed priority: current instruction, then halt, then interrupt
   always_comb begin
      if (exc)                          act_o = step_g ? ACT_EXC_STEP : ACT_EXC;
      else if (done && exc_ebreak_i)    act_o = ACT_EBRK;
      else if (boundary && dreq_live_o) act_o = ACT_HALT;
      else if (done && step_g)          act_o = ACT_STEP;
      else if (boundary && irq_g)       act_o = ACT_IRQ;
      else if (done && jump_req_i)      act_o = ACT_JUMP;
      else                              act_o = ACT_NONE;
   end
endmodule

// File: rtl/trapctl_fsm.sv
module trapctl_fsm
   import trapctl_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  act_e            act_i,
   input  logic            dreq_live_i,
   input  logic [XLEN-1:0] pc_next_i,
   output logic            confirm_o,
   output logic            commit_o,
   output logic            hold_o,
   output logic [XLEN-1:0] dpc_saved_o
);
   typedef enum logic {ST_RUN, ST_CONFIRM} state_e;
   state_e state_q, state_d;
   logic [XLEN-1:0] dpc_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN:     if (act_i == ACT_HALT) state_d = ST_CONFIRM;
         ST_CONFIRM: state_d = ST_RUN;
         default:    state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_RUN;
         dpc_q   <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_RUN && act_i == ACT_HALT) dpc_q <= pc_next_i;
      end
   end

   assign confirm_o   = (state_q == ST_CONFIRM);
   assign commit_o    = confirm_o & dreq_live_i;
   assign hold_o      = (state_q == ST_RUN && act_i == ACT_HALT) | commit_o;
   assign dpc_saved_o = dpc_q;
endmodule

// File: rtl/trapctl_top.sv
module trapctl_top
   import trapctl_pkg::*;
#(
   parameter int unsigned XLEN          = 32,
   parameter int unsigned CODE_W        = 5,
   parameter bit          GATE_IN_DEBUG = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              instr_valid_i,
   input  logic              instr_done_i,
   input  logic              exc_illegal_i,
   input  logic              exc_ecall_i,
   input  logic              exc_ebreak_i,
   input  logic              jump_req_i,
   input  logic [XLEN-1:0]   pc_id_i,
   input  logic [XLEN-1:0]   pc_next_i,
   input  logic [XLEN-1:0]   trap_vec_i,
   input  logic              debug_req_i,
   input  logic              step_en_i,
   input  logic              debug_mode_i,
   input  logic              irq_pending_i,
   input  logic [CODE_W-1:0] irq_id_i,
   output logic              pc_set_o,
   output logic [1:0]        pc_sel_o,
   output logic              instr_valid_clr_o,
   output logic              fetch_hold_o,
   output logic              mepc_we_o,
   output logic [XLEN-1:0]   mepc_o,
   output logic [CODE_W:0]   mcause_o,
   output logic              dpc_we_o,
   output logic [XLEN-1:0]   dpc_o,
   output logic [2:0]        dcause_o,
   output logic              retire_o
);
   localparam int unsigned CAUSE_W = CODE_W + 1;

   generate
      if (XLEN < 16)  begin : g_bad_xlen  $error("XLEN must be at least 16");  end
      if (CODE_W < 4) begin : g_bad_code  $error("CODE_W must hold code 11"); end
   endgenerate

   act_e            act;
   logic            dreq_live, confirm, commit, hold;
   logic [XLEN-1:0] dpc_saved;

   trapctl_arbiter #(.GATE_IN_DEBUG(GATE_IN_DEBUG)) u_arb (
      .debug_mode_i  (debug_mode_i),
      .instr_valid_i (instr_valid_i),
      .instr_done_i  (instr_done_i),
      .exc_illegal_i (exc_illegal_i),
      .exc_ecall_i   (exc_ecall_i),
      .exc_ebreak_i  (exc_ebreak_i),
      .jump_req_i    (jump_req_i),
      .debug_req_i   (debug_req_i),
      .step_en_i     (step_en_i),
      .irq_pending_i (irq_pending_i),
      .act_o         (act),
      .dreq_live_o   (dreq_live),
      .retire_o      (retire_o)
   );

   trapctl_fsm #(.XLEN(XLEN)) u_fsm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .act_i       (act),
      .dreq_live_i (dreq_live),
      .pc_next_i   (pc_next_i),
      .confirm_o   (confirm),
      .commit_o    (commit),
      .hold_o      (hold),
      .dpc_saved_o (dpc_saved)
   );

   logic [CAUSE_W-1:0] exc_cause;
   assign exc_cause = {1'b0, exc_illegal_i ? CODE_W'(EXC_CODE_ILLEGAL) : CODE_W'(EXC_CODE_ECALL)};
   assign fetch_hold_o = hold;

   always_comb begin
      pc_set_o          = 1'b0;
      pc_sel_o          = PCS_NONE;
      instr_valid_clr_o = 1'b0;
      mepc_we_o         = 1'b0;
      mepc_o            = '0;
      mcause_o          = '0;
      dpc_we_o          = 1'b0;
      dpc_o             = '0;
      dcause_o          = '0;
      if (confirm) begin
         if (commit) begin
            pc_set_o = 1'b1; pc_sel_o = PCS_DBG; instr_valid_clr_o = 1'b1;
            dpc_we_o = 1'b1; dpc_o = dpc_saved; dcause_o = DCAUSE_HALT;
         end
      end else begin
         unique case (act)
            ACT_JUMP: begin
               pc_set_o = 1'b1; pc_sel_o = PCS_JUMP;
            end
            ACT_EXC: begin
               pc_set_o = 1'b1; pc_sel_o = PCS_EXC; instr_valid_clr_o = 1'b1;
               mepc_we_o = 1'b1; mepc_o = pc_id_i; mcause_o = exc_cause;
            end
            ACT_EXC_STEP: begin
               pc_set_o = 1'b1; pc_sel_o = PCS_DBG; instr_valid_clr_o = 1'b1;
               mepc_we_o = 1'b1; mepc_o = pc_id_i; mcause_o = exc_cause;
               dpc_we_o = 1'b1; dpc_o = trap_vec_i; dcause_o = DCAUSE_STEP;
            end
            ACT_EBRK: begin
               pc_set_o = 1'b1; pc_sel_o = PCS_DBG; instr_valid_clr_o = 1'b1;
               dpc_we_o = 1'b1; dpc_o = pc_id_i; dcause_o = DCAUSE_EBREAK;
            end
            ACT_STEP: begin
               pc_set_o = 1'b1; pc_sel_o = PCS_DBG; instr_valid_clr_o = 1'b1;
               dpc_we_o = 1'b1; dpc_o = pc_next_i; dcause_o = DCAUSE_STEP;
            end
            ACT_IRQ: begin
               pc_set_o = 1'b1; pc_sel_o = PCS_EXC; instr_valid_clr_o = 1'b1;
               mepc_we_o = 1'b1; mepc_o = pc_next_i; mcause_o = {1'b1, irq_id_i};
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/trapctl_chk.sv
module trapctl_chk #(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned CODE_W = 5
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              instr_valid_i,
   input logic              instr_done_i,
   input logic [XLEN-1:0]   pc_id_i,
   input logic [XLEN-1:0]   pc_next_i,
   input logic              debug_req_i,
   input logic              debug_mode_i,
   input logic              pc_set_o,
   input logic              instr_valid_clr_o,
   input logic              fetch_hold_o,
   input logic              mepc_we_o,
   input logic [XLEN-1:0]   mepc_o,
   input logic [CODE_W:0]   mcause_o,
   input logic              dpc_we_o,
   input logic [XLEN-1:0]   dpc_o,
   input logic [2:0]        dcause_o,
   input logic              retire_o
);
   a_r2_no_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (instr_valid_i && !instr_done_i && !fetch_hold_o) |-> (!pc_set_o && !mepc_we_o && !dpc_we_o));

   a_r3_exc_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mepc_we_o && !mcause_o[CODE_W]) |-> (mepc_o == pc_id_i && pc_set_o && instr_valid_clr_o));

   a_r5_ebreak_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dpc_we_o && dcause_o == 3'd1) |-> (dpc_o == pc_id_i));

   a_r6_halt_after_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dpc_we_o && dcause_o == 3'd3) |-> ($past(fetch_hold_o) && !$past(pc_set_o)));

   a_r7_withdrawn: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(fetch_hold_o && !pc_set_o) && !debug_req_i) |-> (!dpc_we_o && !fetch_hold_o));

   a_r9_irq_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mepc_we_o && mcause_o[CODE_W]) |-> (mepc_o == pc_next_i));

   a_r10_debug_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      debug_mode_i |-> (!(mepc_we_o && mcause_o[CODE_W]) && !(dpc_we_o && dcause_o != 3'd1)));

   a_r13_retire: assert property (@(posedge clk_i) disable iff (!rst_ni)
      retire_o |-> (instr_valid_i && instr_done_i));
endmodule

bind trapctl_top trapctl_chk #(.XLEN(XLEN), .CODE_W(CODE_W)) u_chk (
   .clk_i             (clk_i),
   .rst_ni            (rst_ni),
   .instr_valid_i     (instr_valid_i),
   .instr_done_i      (instr_done_i),
   .pc_id_i           (pc_id_i),
   .pc_next_i         (pc_next_i),
   .debug_req_i       (debug_req_i),
   .debug_mode_i      (debug_mode_i),
   .pc_set_o          (pc_set_o),
   .instr_valid_clr_o (instr_valid_clr_o),
   .fetch_hold_o      (fetch_hold_o),
   .mepc_we_o         (mepc_we_o),
   .mepc_o            (mepc_o),
   .mcause_o          (mcause_o),
   .dpc_we_o          (dpc_we_o),
   .dpc_o             (dpc_o),
   .dcause_o          (dcause_o),
   .retire_o          (retire_o)
);

// File: tb/trapctl_top_tb_top.sv
`timescale 1ns/1ps
module trapctl_top_tb_top;
   localparam int unsigned XLEN = 32;
   localparam int unsigned CODE_W = 5;

   typedef struct packed {
      logic              valid, done, ill, ecall, ebrk, jump;
      logic [XLEN-1:0]   pc_id, pc_next;
      logic              dreq, step, dmode, irq;
      logic [CODE_W-1:0] irq_id;
   } stim_t;

   typedef struct packed {
      logic              pc_set;
      logic [1:0]        pc_sel;
      logic              clr, hold, mepc_we;
      logic [XLEN-1:0]   mepc;
      logic [CODE_W:0]   mcause;
      logic              dpc_we;
      logic [XLEN-1:0]   dpc;
      logic [2:0]        dcause;
      logic              retire;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   stim_t s, st;
   logic [XLEN-1:0] trap_vec = 32'h0000_0800;

   logic              pc_set, clr, hold, mepc_we, dpc_we, retire;
   logic [1:0]        pc_sel;
   logic [XLEN-1:0]   mepc, dpc;
   logic [CODE_W:0]   mcause;
   logic [2:0]        dcause;

   trapctl_top #(.XLEN(XLEN), .CODE_W(CODE_W)) dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .instr_valid_i(s.valid), .instr_done_i(s.done),
      .exc_illegal_i(s.ill), .exc_ecall_i(s.ecall), .exc_ebreak_i(s.ebrk),
      .jump_req_i(s.jump), .pc_id_i(s.pc_id), .pc_next_i(s.pc_next),
      .trap_vec_i(trap_vec), .debug_req_i(s.dreq), .step_en_i(s.step),
      .debug_mode_i(s.dmode), .irq_pending_i(s.irq), .irq_id_i(s.irq_id),
      .pc_set_o(pc_set), .pc_sel_o(pc_sel), .instr_valid_clr_o(clr),
      .fetch_hold_o(hold), .mepc_we_o(mepc_we), .mepc_o(mepc), .mcause_o(mcause),
      .dpc_we_o(dpc_we), .dpc_o(dpc), .dcause_o(dcause), .retire_o(retire)
   );

   int checks = 0;
   int errors = 0;
   exp_t  exp_q[$];
   string tag_q[$];
   bit    done_all = 1'b0;

   // Driver: applies staged stimulus at the falling edge and queues the expectation
   task automatic cyc(input string tag, input exp_t e);
      @(negedge clk);
      s = st;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   // Monitor: compares outputs mid-low-phase against queued expectation
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (exp_q.size() > 0) begin
            exp_t e, g;
            string t;
            bit bad;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            g = '{pc_set, pc_sel, clr, hold, mepc_we, mepc, mcause, dpc_we, dpc, dcause, retire};
            bad = (g.pc_set != e.pc_set) || (g.pc_sel != e.pc_sel) || (g.clr != e.clr) ||
                  (g.hold != e.hold) || (g.mepc_we != e.mepc_we) || (g.dpc_we != e.dpc_we) ||
                  (g.retire != e.retire);
            if (e.mepc_we && (g.mepc != e.mepc || g.mcause != e.mcause)) bad = 1'b1;
            if (e.dpc_we && (g.dpc != e.dpc || g.dcause != e.dcause)) bad = 1'b1;
            checks++;
            if (bad) begin
               errors++;
               $display("FAIL %s: got set=%0b sel=%0d clr=%0b hold=%0b mwe=%0b mepc=%h mc=%h dwe=%0b dpc=%h dc=%0d ret=%0b exp set=%0b sel=%0d clr=%0b hold=%0b mwe=%0b mepc=%h mc=%h dwe=%0b dpc=%h dc=%0d ret=%0b",
                  t, g.pc_set, g.pc_sel, g.clr, g.hold, g.mepc_we, g.mepc, g.mcause, g.dpc_we, g.dpc, g.dcause, g.retire,
                  e.pc_set, e.pc_sel, e.clr, e.hold, e.mepc_we, e.mepc, e.mcause, e.dpc_we, e.dpc, e.dcause, e.retire);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done_all) begin
         errors++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   function automatic stim_t idle();
      stim_t x = '0;
      x.pc_id = 32'h0000_0100;
      x.pc_next = 32'h0000_0104;
      x.irq_id = 5'd7;
      return x;
   endfunction

   exp_t e;

   initial begin
      st = idle();
      s  = st;
      // R1: reset state
      e = '0; cyc("R1 reset quiet", e);
      cyc("R1 reset quiet 2", e);
      @(negedge clk); rst_n = 1'b1;
      e = '0; cyc("R1 idle no action", e);

      // R13: legal completion retires
      st = idle(); st.valid = 1; st.done = 1;
      e = '0; e.retire = 1; cyc("R13 legal retire", e);

      // R2: busy instruction with irq and halt request pending
      st = idle(); st.valid = 1; st.irq = 1; st.dreq = 1;
      e = '0; cyc("R2 busy no abort", e);
      cyc("R2 busy no abort 2", e);

      // R3: illegal exception beats halt and irq; illegal still retires (R13)
      st = idle(); st.valid = 1; st.done = 1; st.ill = 1; st.dreq = 1; st.irq = 1;
      e = '0; e.pc_set = 1; e.pc_sel = 2; e.clr = 1; e.mepc_we = 1;
      e.mepc = 32'h100; e.mcause = 6'd2; e.retire = 1;
      cyc("R3 illegal beats halt irq, R13 illegal retires", e);

      // R3: environment call cause
      st = idle(); st.valid = 1; st.done = 1; st.ecall = 1;
      e = '0; e.pc_set = 1; e.pc_sel = 2; e.clr = 1; e.mepc_we = 1;
      e.mepc = 32'h100; e.mcause = 6'd11; e.retire = 1;
      cyc("R3 ecall cause", e);

      // R4: illegal jump goes to handler, not jump target
      st = idle(); st.valid = 1; st.done = 1; st.jump = 1; st.ill = 1;
      e = '0; e.pc_set = 1; e.pc_sel = 2; e.clr = 1; e.mepc_we = 1;
      e.mepc = 32'h100; e.mcause = 6'd2; e.retire = 1;
      cyc("R4 illegal jump", e);
      st = idle(); st.valid = 1; st.done = 1; st.jump = 1;
      e = '0; e.pc_set = 1; e.pc_sel = 1; e.retire = 1;
      cyc("R4 legal jump", e);

      // R5: breakpoint beats halt request
      st = idle(); st.valid = 1; st.done = 1; st.ebrk = 1; st.dreq = 1;
      e = '0; e.pc_set = 1; e.pc_sel = 3; e.clr = 1; e.dpc_we = 1;
      e.dpc = 32'h100; e.dcause = 3'd1; e.retire = 1;
      cyc("R5 ebreak", e);

      // R6 and R8: halt with irq at idle, confirmed with changed next PC
      st = idle(); st.dreq = 1; st.irq = 1;
      e = '0; e.hold = 1; cyc("R6 R8 halt phase one", e);
      st = idle(); st.dreq = 1; st.irq = 1; st.pc_next = 32'h200;
      e = '0; e.pc_set = 1; e.pc_sel = 3; e.clr = 1; e.hold = 1; e.dpc_we = 1;
      e.dpc = 32'h104; e.dcause = 3'd3;
      cyc("R6 R8 halt commit", e);

      // R7: withdrawal in confirmation cycle
      st = idle(); st.dreq = 1;
      e = '0; e.hold = 1; cyc("R7 halt phase one", e);
      st = idle();
      e = '0; cyc("R7 abandoned", e);
      cyc("R7 stays running", e);

      // R9: interrupt at idle
      st = idle(); st.irq = 1;
      e = '0; e.pc_set = 1; e.pc_sel = 2; e.clr = 1; e.mepc_we = 1;
      e.mepc = 32'h104; e.mcause = 6'h27;
      cyc("R9 irq idle", e);

      // R10: debug mode ignores irq, halt, step
      st = idle(); st.dmode = 1; st.irq = 1; st.dreq = 1; st.step = 1; st.valid = 1; st.done = 1;
      e = '0; e.retire = 1; cyc("R10 gated in debug", e);
      st = idle(); st.dmode = 1; st.irq = 1; st.dreq = 1;
      e = '0; cyc("R10 gated idle", e);

      // R11: single step
      st = idle(); st.step = 1; st.valid = 1; st.done = 1;
      e = '0; e.pc_set = 1; e.pc_sel = 3; e.clr = 1; e.dpc_we = 1;
      e.dpc = 32'h104; e.dcause = 3'd4; e.retire = 1;
      cyc("R11 step completes", e);
      st = idle(); st.step = 1;
      e = '0; cyc("R11 step idle no entry", e);

      // R12: stepped instruction faults
      st = idle(); st.step = 1; st.valid = 1; st.done = 1; st.ill = 1;
      e = '0; e.pc_set = 1; e.pc_sel = 3; e.clr = 1; e.mepc_we = 1;
      e.mepc = 32'h100; e.mcause = 6'd2; e.dpc_we = 1; e.dpc = 32'h800;
      e.dcause = 3'd4; e.retire = 1;
      cyc("R12 step with exception", e);

      st = idle();
      e = '0; cyc("R1 quiet at end", e);
      repeat (3) @(negedge clk);
      done_all = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule